// File: doc/BRIEF.md
# Presettable Cascadable Up-Down Counter

This block is a synchronous binary up/down counter built from identical 4-bit stages. Each stage can be preset from a data bus, can count in either direction, or can hold its value. All state changes happen on the rising clock edge. A parameterized wrapper chains the stages into one wider counter. Each stage's active-low terminal-count output drives the trickle enable of the stage above it, so a carry or borrow ripples through a combinational lookahead chain and never through the clock.

Two active-low count enables gate counting. The parallel enable goes to every stage and does not affect terminal count. The trickle enable goes only to the lowest stage, and it also qualifies the terminal-count output. The direction input selects whether the terminal value is all ones (counting up) or zero (counting down). A synchronous active-low reset clears the counter to zero. Reset is there for testability.

Top module: `udc_cascade`

## Requirements
- R1: When `rst_n` is low at a rising edge, `q` becomes 0 on that edge. Reset overrides loading and counting.
- R2: When `rst_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` on that edge, whatever the enables and the direction are.
- R3: When `load_n`, `cnt_en_n` and `chain_en_n` are high, low and low respectively and `count_up` is 1, `q` increments by one modulo 2^(STAGE_W*STAGES). The all-ones value wraps to 0, with carries crossing stage boundaries.
- R4: Under the same enables with `count_up` 0, `q` decrements by one. The value 0 wraps to all ones, with borrows crossing stage boundaries.
- R5: With `rst_n` and `load_n` high, `q` holds its value if `cnt_en_n` or `chain_en_n` is high.
- R6: `tc_n` is combinational. It is 0 exactly when `chain_en_n` is 0 and either `count_up` is 1 with `q` all ones, or `count_up` is 0 with `q` zero. Otherwise it is 1. `cnt_en_n` has no effect on it, and a change of direction takes effect on it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Parallel load, active low, highest priority after reset |
| cnt_en_n | input | 1 | Parallel count enable to all stages, active low |
| chain_en_n | input | 1 | Trickle count enable into the lowest stage, active low |
| count_up | input | 1 | 1 counts up, 0 counts down |
| din | input | STAGE_W*STAGES | Preset value |
| q | output | STAGE_W*STAGES | Counter state |
| tc_n | output | 1 | Terminal count of the top stage, active low |

## Verification
A wrong state in any stage shows on `q` one clock edge after the faulty update. It shows on `tc_n` in the same cycle, though only if that state is the terminal value for the current direction. A broken lookahead link between stages is not visible on the low nibble. It appears only at a stage boundary, for example on the step from 0x0F to 0x10 or from 0x00 to 0xFF, when the upper stage fails to step. For that reason the stimulus deliberately steers the counter through both wrap points and through stage boundaries, and compares every cycle against a reference value.

// File: rtl/udc_pkg.sv
// Shared types for the up/down counter stages.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package udc_pkg;

    // Action one stage takes on the next rising edge (reset handled apart).
    typedef enum logic [1:0] {
        UDC_HOLD = 2'd0,
        UDC_LOAD = 2'd1,
        UDC_INC  = 2'd2,
        UDC_DEC  = 2'd3
    } udc_op_e;

    // Resolve the stage controls into one action; loading wins over counting.
    function automatic udc_op_e udc_pick_op(
        input logic load_n,
        input logic par_en_n,
        input logic trk_en_n,
        input logic up
    );
        if (!load_n)
            return UDC_LOAD;
        else if (!par_en_n && !trk_en_n)
            return up ? UDC_INC : UDC_DEC;
        else
            return UDC_HOLD;
    endfunction

endpackage

// File: rtl/udc_mode_sel.sv
// Mode selector for one counter stage.
// Turns the active-low controls and the direction into a single action code.
// Assumes: reset is handled by the state register, not here.
module udc_mode_sel
    import udc_pkg::*;
(
    input  logic    load_n,
    input  logic    par_en_n,
    input  logic    trk_en_n,
    input  logic    up,
    output udc_op_e op
);

    // Combinational priority decode of the stage controls.
    always_comb begin
        op = udc_pick_op(load_n, par_en_n, trk_en_n, up);
    end

endmodule

// File: rtl/udc_term_decode.sv
// Terminal-count decoder for one stage.
// Drives low when the stage sits at its last value for the current direction
// (all ones going up, zero going down) and the incoming trickle enable is low.
// Assumes: output is purely combinational and may glitch; not used as a clock.
module udc_term_decode #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         up,
    input  logic         trk_en_n,
    output logic         tc_n
);

    logic at_end;

    // Pick the end value that matches the direction.
    always_comb begin
        at_end = up ? (&q) : ~(|q);
    end

    // Qualify with the trickle enable so a chain forms a lookahead carry.
    always_comb begin
        tc_n = ~(at_end & ~trk_en_n);
    end

endmodule

// File: rtl/udc_stage.sv
// One W-bit presettable up/down counter stage.
// Synchronous active-low clear, then load, then count, then hold.
// Assumes: all inputs are sampled only at the rising edge of clk.
module udc_stage
    import udc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic         par_en_n,
    input  logic         trk_en_n,
    input  logic         up,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc_n
);

    localparam logic [W-1:0] ONE = W'(1);

    udc_op_e      op;
    logic [W-1:0] q_r;

    udc_mode_sel u_mode (
        .load_n   (load_n),
        .par_en_n (par_en_n),
        .trk_en_n (trk_en_n),
        .up       (up),
        .op       (op)
    );

    // State register; wraparound is the natural modulo of W-bit arithmetic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            unique case (op)
                UDC_LOAD: q_r <= din;
                UDC_INC:  q_r <= q_r + ONE;
                UDC_DEC:  q_r <= q_r - ONE;
                default:  q_r <= q_r;
            endcase
        end
    end

    udc_term_decode #(.W(W)) u_term (
        .q        (q_r),
        .up       (up),
        .trk_en_n (trk_en_n),
        .tc_n     (tc_n)
    );

    // Drive the state output.
    always_comb begin
        q = q_r;
    end

endmodule

// File: rtl/udc_cascade.sv
// Chain of STAGES up/down counter stages forming one wide counter.
// Each stage's terminal count feeds the trickle enable of the stage above.
// Clock, reset, load, parallel enable and direction are shared by all stages.
// Assumes: the lookahead path through all stages settles within one cycle.
module udc_cascade #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_n,
    input  logic                        cnt_en_n,
    input  logic                        chain_en_n,
    input  logic                        count_up,
    input  logic [STAGE_W*STAGES-1:0]   din,
    output logic [STAGE_W*STAGES-1:0]   q,
    output logic                        tc_n
);

    localparam int TOTAL_W = STAGE_W * STAGES;

    logic [STAGES:0] trk_n;   // trk_n[i] enters stage i; trk_n[STAGES] leaves the top

    // Lowest stage takes the external trickle enable.
    always_comb begin
        trk_n[0] = chain_en_n;
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        udc_stage #(.W(STAGE_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_n   (load_n),
            .par_en_n (cnt_en_n),
            .trk_en_n (trk_n[g]),
            .up       (count_up),
            .din      (din[g*STAGE_W +: STAGE_W]),
            .q        (q[g*STAGE_W +: STAGE_W]),
            .tc_n     (trk_n[g+1])
        );
    end

    // Top stage's terminal count is the chain's terminal count.
    always_comb begin
        tc_n = trk_n[STAGES];
    end

endmodule

// File: rtl/udc_cascade_chk.sv
// Property checker for udc_cascade, attached by bind.
// Treats the chain as one TOTAL_W-bit counter, seen only at its ports.
module udc_cascade_chk #(
    parameter int TOTAL_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_n,
    input logic               cnt_en_n,
    input logic               chain_en_n,
    input logic               count_up,
    input logic [TOTAL_W-1:0] din,
    input logic [TOTAL_W-1:0] q,
    input logic               tc_n
);

    localparam logic [TOTAL_W-1:0] ONE = TOTAL_W'(1);

    logic past_ok;   // previous edge saw reset released

    // Track whether the previous edge was outside reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    p_clear_r1: assert property (@(posedge clk)
        (!rst_n) |=> (q == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(load_n)) |-> (q == $past(din)));

    p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(load_n) && !$past(cnt_en_n) && !$past(chain_en_n) && $past(count_up))
        |-> (q == $past(q) + ONE));

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(load_n) && !$past(cnt_en_n) && !$past(chain_en_n) && !$past(count_up))
        |-> (q == $past(q) - ONE));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(load_n) && ($past(cnt_en_n) || $past(chain_en_n)))
        |-> $stable(q));

    p_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (tc_n == !(!chain_en_n && (count_up ? (q == '1) : (q == '0)))));

endmodule

bind udc_cascade udc_cascade_chk #(.TOTAL_W(STAGE_W*STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .cnt_en_n   (cnt_en_n),
    .chain_en_n (chain_en_n),
    .count_up   (count_up),
    .din        (din),
    .q          (q),
    .tc_n       (tc_n)
);

// File: tb/sim_udc_cascade.sv
// Self-checking bench for udc_cascade: directed corners plus seeded random.
module sim_udc_cascade;

    localparam int STAGE_W = 4;
    localparam int STAGES  = 2;
    localparam int TW      = STAGE_W * STAGES;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic          cnt_en_n = 1'b1;
    logic          chain_en_n = 1'b1;
    logic          count_up = 1'b1;
    logic [TW-1:0] din = '0;
    logic [TW-1:0] q;
    logic          tc_n;

    int unsigned   n_chk = 0;
    int unsigned   n_fail = 0;
    logic [TW-1:0] model = '0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    udc_cascade #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .count_up   (count_up),
        .din        (din),
        .q          (q),
        .tc_n       (tc_n)
    );

    // Next counter value from the requirements (R1..R5).
    function automatic logic [TW-1:0] f_next(logic [TW-1:0] cur, logic rn, logic ld,
                                             logic ce, logic te, logic up, logic [TW-1:0] d);
        if (!rn) return '0;
        if (!ld) return d;
        if (!ce && !te) return up ? cur + TW'(1) : cur - TW'(1);
        return cur;
    endfunction

    // Expected terminal count from the requirement (R6).
    function automatic logic f_tc(logic [TW-1:0] cur, logic te, logic up);
        logic at_end;
        at_end = up ? (cur == '1) : (cur == '0);
        return !(at_end && !te);
    endfunction

    function automatic string f_tag(logic rn, logic ld, logic ce, logic te, logic up);
        if (!rn) return "R1";
        if (!ld) return "R2";
        if (!ce && !te) return up ? "R3" : "R4";
        return "R5";
    endfunction

    task automatic check(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive, check tc_n mid-cycle, clock, check q.
    task automatic step(logic rn, logic ld, logic ce, logic te, logic up, logic [TW-1:0] d);
        string tag;
        @(negedge clk);
        rst_n = rn; load_n = ld; cnt_en_n = ce; chain_en_n = te; count_up = up; din = d;
        #1;
        check("R6", TW'(tc_n), TW'(f_tc(model, te, up)));
        tag = f_tag(rn, ld, ce, te, up);
        model = f_next(model, rn, ld, ce, te, up, d);
        @(posedge clk);
        #1;
        check(tag, q, model);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset value, and reset beats a load
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5);
        // R2: load with enables active, load with enables idle
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFE);
        // R3: count up through all-ones and wrap to zero (R6 low at FF)
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        // R6: terminal count ignores cnt_en_n; R5 hold with parallel enable high
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        // R6: trickle high forces tc_n high at terminal; R5 hold on trickle
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
        // R3: carry across the stage boundary 0F -> 10
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0F);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        // R4: borrow across the boundary 10 -> 0F, and wrap 00 -> FF
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        // R6: direction flip at FF changes tc_n in the same cycle
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        // Random phase, biased toward counting and near-terminal loads
        for (int i = 0; i < 600; i++) begin
            logic          r_rn, r_ld, r_ce, r_te, r_up;
            logic [TW-1:0] r_d;
            r_rn = ($urandom % 50) != 0;
            r_ld = ($urandom % 8) != 0;
            r_ce = ($urandom % 5) == 0;
            r_te = ($urandom % 5) == 0;
            r_up = ($urandom % 2) != 0;
            case ($urandom % 4)
                0: r_d = '1;
                1: r_d = '0;
                2: r_d = TW'(8'h0F);
                default: r_d = TW'($urandom);
            endcase
            step(r_rn, r_ld, r_ce, r_te, r_up, r_d);
        end
        finish_run();
    end

endmodule